// File: doc/BRIEF.md
# UART Transmit Queue with Status Flags

This block sits between a CPU-facing write port and a UART serializer. Words written by software are queued in a small FIFO. The serializer takes them one at a time from the head of the queue. The block keeps four flags, each derived from the queue and transmitter state: room-available, queue-empty, free-slot threshold and transmission-complete. Any flag whose enable bit is set drives a single registered interrupt line. Bit timing and serial shifting belong to the serializer and are not part of this block.

Both data edges use valid/ready. On the write edge, `wr_ready` is the room-available flag, and a word transfers only on a cycle where `wr_valid` and `wr_ready` are both high. A word offered while `wr_ready` is low is dropped, and the queue contents are left as they were. On the read edge, `out_valid` marks a head word on `out_data`, and the serializer removes that word by holding `out_ready` high for the cycle. The producer may lower `wr_valid` at any time, and the consumer may hold `out_ready` low as long as it needs to.

A flush pulse starts a drain that discards one queued word per clock. While the drain runs, both data edges are closed. The transmission-complete flag is built to track the state of the serial line. It rises when a frame ends with nothing left queued. A clear pulse or any accepted write lowers it. It is held high whenever the transmitter is disabled and no frame is being sent.

Top module: `uart_txq_status`

## Requirements
- R1: Words accepted through the write handshake leave on `out_data` in the order they were written.
- R2: With `DEPTH` words held, `wr_ready` is low, and any word offered then is discarded without altering the queued data or the word count.
- R3: `out_valid` is high whenever the queue holds data and no flush is running. A handshake with `out_ready` removes the head word, and the next word appears on the following cycle.
- R4: `empty_flag` is high exactly when the queue holds no data.
- R5: A one-cycle `flush_req` starts a drain that removes one word at each clock edge, beginning with the edge at which the request is sampled. While words remain, `wr_ready` and `out_valid` stay low. After the edge that removes the last word, `wr_ready` and `empty_flag` go high in the same cycle.
- R6: `thr_flag` is high while the number of free slots (`DEPTH` minus the words held) is greater than or equal to `free_thr`.
- R7: A `frame_done` pulse while the queue is empty sets `tc_flag` at the next edge. A `frame_done` pulse while words are still queued leaves `tc_flag` unchanged.
- R8: With the transmitter enabled, a `clr_tc` pulse or an accepted write clears `tc_flag` at the next edge. A clear takes priority over a set in the same cycle.
- R9: A frame is in progress from the edge that pops a word until the edge that sees `frame_done`. While `tx_en` is low and no frame is in progress, `tc_flag` is forced high at the next edge, and `clr_tc` has no effect. While a frame is still in progress, disabling the transmitter does not set the flag.
- R10: `irq` is a register that goes high one cycle after any flag is high with its enable bit set. The enable bits are: bit 0 room-available, bit 1 empty, bit 2 threshold, bit 3 complete.
- R11: After reset the queue is empty, `wr_ready`, `empty_flag` and `tc_flag` are high, and `out_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | CPU offers a word |
| wr_data | input | DW | Word to queue |
| wr_ready | output | 1 | Room-available flag and write handshake ready |
| out_valid | output | 1 | Head word available to the serializer |
| out_data | output | DW | Head word |
| out_ready | input | 1 | Serializer takes the head word |
| frame_done | input | 1 | Pulse when the serializer finishes a frame |
| tx_en | input | 1 | Transmitter enable |
| flush_req | input | 1 | Pulse that starts a queue drain |
| free_thr | input | $clog2(DEPTH)+1 | Free-slot threshold |
| clr_tc | input | 1 | Pulse that clears the complete flag |
| irq_en | input | 4 | Per-flag interrupt enables |
| empty_flag | output | 1 | Queue holds no data |
| thr_flag | output | 1 | Free slots at or above the threshold |
| tc_flag | output | 1 | Transmission complete |
| irq | output | 1 | Registered interrupt |

## Verification
The queue is tested in three ways. It is filled to capacity, a further word is offered while it is full, and then it is drained word by word. This pattern separates correct ordering from slot-overwrite faults and from full-detection faults. A partial fill is followed by a flush, and the handshake and empty outputs are checked at every edge of the drain. This shows whether the drain runs one word per cycle and whether room-available and empty rise on the same edge. The complete flag is then stepped through frame-end with the queue empty and with data queued, clearing by pulse and by write, and disabling the transmitter during a frame and while idle. This shows the priority order among force, clear and set.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int NUM_FLAGS = 4;

  // Bit order matters: it defines the irq_en positions.
  typedef struct packed {
    logic tc;     // bit 3
    logic thr;    // bit 2
    logic empty;  // bit 1
    logic nf;     // bit 0
  } txq_flags_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          flush_req,
  output logic [CW-1:0] level,
  output logic          push,
  output logic          pop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_n;
  logic          pend, flushing, rd_adv;

  initial begin
    if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
      $error("DEPTH must be a power of two, at least 2");
  end

  assign flushing  = flush_req | pend;
  assign wr_ready  = (count != CW'(DEPTH)) && !pend;
  assign out_valid = (count != '0) && !pend;
  assign push      = wr_valid && wr_ready;
  assign pop       = out_valid && out_ready;
  assign rd_adv    = (count != '0) && (pop || flushing);
  assign count_n   = count + CW'(push) - CW'(rd_adv);
  assign out_data  = mem[rd_ptr];
  assign level     = count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      pend   <= 1'b0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + AW'(1);
      if (rd_adv) rd_ptr <= rd_ptr + AW'(1);
      count <= count_n;
      pend  <= flushing && (count_n != '0);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_ptr == $past(wr_ptr))); // R2
  AST_FLUSH_CLOSES_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && count > CW'(1)) |=> (!wr_ready && !out_valid)); // R5
  AST_DRAIN_ENDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> (count == '0 && wr_ready)); // R5
endmodule

// File: rtl/txq_flags.sv
module txq_flags
  import txq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic          wr_ready,
  input  logic          push,
  input  logic          pop,
  input  logic          frame_done,
  input  logic          tx_en,
  input  logic          clr_tc,
  input  logic [CW-1:0] free_thr,
  output txq_flags_t    flags
);
  logic          busy, tc;
  logic [CW-1:0] free_slots;

  assign free_slots  = CW'(DEPTH) - level;
  assign flags.nf    = wr_ready;
  assign flags.empty = (level == '0);
  assign flags.thr   = (free_slots >= free_thr);
  assign flags.tc    = tc;

  // A frame is in flight from the pop until the serializer reports its end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= 1'b0;
    else if (pop)        busy <= 1'b1;
    else if (frame_done) busy <= 1'b0;
  end

  // Priority: idle-disable force, then clear, then frame-end set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 tc <= 1'b1;
    else if (!tx_en && !busy)                   tc <= 1'b1;
    else if (clr_tc || push)                    tc <= 1'b0;
    else if (frame_done && level == '0)         tc <= 1'b1;
  end

  AST_TC_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> tc); // R9
  AST_TC_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && (push || clr_tc)) |=> !tc); // R8
  AST_TC_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && level == '0 && !push && !clr_tc) |=> tc); // R7
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_vec,
  input  logic [N-1:0] en,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flag_vec & en);
  end

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_vec & en)) |=> irq); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_vec & en)) |=> !irq); // R10
endmodule

// File: rtl/uart_txq_status.sv
module uart_txq_status
  import txq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          frame_done,
  input  logic          tx_en,
  input  logic          flush_req,
  input  logic [CW-1:0] free_thr,
  input  logic          clr_tc,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic          empty_flag,
  output logic          thr_flag,
  output logic          tc_flag,
  output logic          irq
);
  logic [CW-1:0] level;
  logic          push, pop;
  txq_flags_t    flags;

  txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .wr_valid, .wr_data, .wr_ready, .out_valid, .out_data,
    .out_ready, .flush_req, .level, .push, .pop
  );

  txq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk, .rst_n, .level, .wr_ready, .push, .pop, .frame_done, .tx_en,
    .clr_tc, .free_thr, .flags
  );

  txq_irq #(.N(NUM_FLAGS)) u_irq (
    .clk, .rst_n, .flag_vec(flags), .en(irq_en), .irq
  );

  assign empty_flag = flags.empty;
  assign thr_flag   = flags.thr;
  assign tc_flag    = flags.tc;

  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    empty_flag |-> !out_valid); // R4
endmodule

// File: tb/test_uart_txq_status.sv
`timescale 1ns/1ps
module test_uart_txq_status;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, out_ready = 0, frame_done = 0, tx_en = 0;
  logic flush_req = 0, clr_tc = 0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] free_thr = CW'(3);
  logic [3:0] irq_en = '0;
  logic wr_ready, out_valid, empty_flag, thr_flag, tc_flag, irq;
  logic [DW-1:0] out_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_txq_status #(.DW(DW), .DEPTH(DEPTH)) i_uart_txq_status (
    .clk, .rst_n, .wr_valid, .wr_data, .wr_ready, .out_valid, .out_data,
    .out_ready, .frame_done, .tx_en, .flush_req, .free_thr, .clr_tc,
    .irq_en, .empty_flag, .thr_flag, .tc_flag, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
    chk("R11 wr_ready", wr_ready, 1);
    chk("R11 empty", empty_flag, 1);
    chk("R11 tc", tc_flag, 1);
    chk("R11 out_valid", out_valid, 0);
    chk("R11 irq", irq, 0);
  endtask

  task automatic t_fill_drain();
    tx_en = 1;
    for (int i = 0; i < DEPTH; i++) begin
      wr_valid = 1; wr_data = DW'(8'h30 + i); tick();
    end
    wr_valid = 0;
    chk("R2 full wr_ready", wr_ready, 0);
    chk("R4 not empty", empty_flag, 0);
    chk("R6 no free slots", thr_flag, 0);
    wr_valid = 1; wr_data = 8'hEE; tick(); tick(); wr_valid = 0;
    chk("R2 still full", wr_ready, 0);
    chk("R2 head intact", out_data, 8'h30);
    out_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 valid", out_valid, 1);
      chk("R1 order", out_data, 32'h30 + i);
      tick();
    end
    out_ready = 0;
    chk("R3 drained", out_valid, 0);
    chk("R2 no extra word", empty_flag, 1);
  endtask

  task automatic t_thr_flush();
    free_thr = CW'(3);
    for (int n = 1; n <= 6; n++) begin
      wr_valid = 1; wr_data = DW'(n); tick();
      chk("R6 threshold", thr_flag, ((DEPTH - n) >= 3) ? 1 : 0);
    end
    wr_valid = 0;
    flush_req = 1; tick(); flush_req = 0;
    for (int k = 0; k < 5; k++) begin
      chk("R5 wr_ready low", wr_ready, 0);
      chk("R5 out_valid low", out_valid, 0);
      chk("R5 not empty yet", empty_flag, 0);
      tick();
    end
    chk("R5 wr_ready rises", wr_ready, 1);
    chk("R5 empty rises", empty_flag, 1);
    chk("R4 empty after flush", out_valid, 0);
  endtask

  task automatic t_complete();
    tx_en = 1;
    frame_done = 1; tick(); frame_done = 0;
    chk("R7 set on empty", tc_flag, 1);
    clr_tc = 1; tick(); clr_tc = 0;
    chk("R8 clear pulse", tc_flag, 0);
    frame_done = 1; tick(); frame_done = 0;
    chk("R7 set again", tc_flag, 1);
    wr_valid = 1; wr_data = 8'h5A; tick(); wr_valid = 0;
    chk("R8 write clears", tc_flag, 0);
    frame_done = 1; tick(); frame_done = 0;
    chk("R7 data queued", tc_flag, 0);
    out_ready = 1; tick(); out_ready = 0;
    tx_en = 0; tick(); tick();
    chk("R9 busy holds", tc_flag, 0);
    frame_done = 1; tick(); frame_done = 0;
    chk("R7 frame end", tc_flag, 1);
    clr_tc = 1; tick(); clr_tc = 0;
    chk("R9 clear ignored when idle off", tc_flag, 1);
    tx_en = 1;
  endtask

  task automatic t_irq();
    irq_en = 4'b1000; tick();
    chk("R10 tc irq", irq, 1);
    clr_tc = 1; tick(); clr_tc = 0; tick();
    chk("R10 tc irq drops", irq, 0);
    irq_en = 4'b0010; tick();
    chk("R10 empty irq", irq, 1);
    irq_en = 4'b0100; free_thr = CW'(9); tick(); tick();
    chk("R6 above capacity", thr_flag, 0);
    chk("R10 thr masked by flag", irq, 0);
    free_thr = CW'(DEPTH); tick(); tick();
    chk("R6 equal boundary", thr_flag, 1);
    chk("R10 thr irq", irq, 1);
    irq_en = 4'b0001; tick();
    chk("R10 nf irq", irq, 1);
    irq_en = 4'b0000; tick();
    chk("R10 all masked", irq, 0);
  endtask

  initial begin
    t_reset();
    t_fill_drain();
    t_thr_flush();
    t_complete();
    t_irq();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule